// File: doc/BRIEF.md
# Dual-Width Parallel Bus Port

This block sits between the pads of an asynchronous parallel memory bus and the memory core behind it. It watches the active-low chip select, output enable and write enable strobes, together with a width-select input. From these it produces single-cycle internal read and write strobes in the core clock domain. It also drives the per-pin output enables and output data for a 16-bit data bus, which is split at the pad into input, output and enable vectors.

Two widths are supported. In wide (16-bit) mode, all sixteen data pins carry data. In narrow (8-bit) mode, only the lower eight pins carry data. Pins 14 to 8 stay undriven, and pin 15 becomes an input that supplies the half-word select bit. That bit sits below address bit 0. On reads it chooses which half of the core's 16-bit word appears on the low pins. On writes it chooses which byte lane is written.

A write is committed once, when the cycle ends: either write enable or chip select rises, whichever comes first. The address, data and lanes committed are those seen in the last sampled cycle of the write. The bus inputs are assumed to be already synchronous to `clk`.

Top module: `dual_width_bus_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `arr_rd_stb` and `arr_wr_stb` are 0. After reset, `arr_wr_be` and `arr_wr_data` read as 0.
- R2: In wide mode (`bus_wide`=1), a read cycle drives all 16 pins: `dq_oe`=16'hFFFF and `dq_o` equals `arr_rd_word`. A read cycle means `bus_cs_n`=0, `bus_oe_n`=0 and `bus_we_n`=1.
- R3: In narrow mode (`bus_wide`=0), `dq_oe[15:8]` is always 0. During a read cycle `dq_oe`=16'h00FF. `dq_o[7:0]` is `arr_rd_word[7:0]` when `dq_i[15]`=0 and `arr_rd_word[15:8]` when `dq_i[15]`=1.
- R4: `dq_oe` is 16'h0000 whenever `bus_cs_n` or `bus_oe_n` is high.
- R5: On the first clock edge that samples a read cycle, `arr_rd_stb` goes high for exactly one cycle. `arr_rd_addr` follows `bus_addr`. `arr_rd_hi` is `dq_i[15]` in narrow mode and 0 in wide mode.
- R6: A write cycle is `bus_cs_n`=0, `bus_we_n`=0 and `bus_oe_n`=1. It produces exactly one `arr_wr_stb` pulse, on the clock edge that first samples the cycle ended by `bus_we_n` or `bus_cs_n` going high. The address, data and lanes presented are those from the last sampled write cycle.
- R7: A wide-mode write presents `arr_wr_data`=`dq_i` and `arr_wr_be`=2'b11.
- R8: A narrow-mode write presents `dq_i[7:0]` in both halves of `arr_wr_data`. `arr_wr_be` is 2'b01 when `dq_i[15]`=0 and 2'b10 when `dq_i[15]`=1.
- R9: With `bus_cs_n`, `bus_oe_n` and `bus_we_n` all low, no strobe of either kind is produced and `dq_oe` is 0. A write in progress that runs into this state is dropped without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| bus_addr | input | ADDR_W | Word address from the bus |
| dq_i | input | 16 | Data pad input values |
| dq_o | output | 16 | Data pad output values |
| dq_oe | output | 16 | Per-pin output enables |
| arr_rd_word | input | 16 | Word returned by the core for `arr_rd_addr` |
| arr_rd_addr | output | ADDR_W | Read word address to the core |
| arr_rd_hi | output | 1 | Upper half selected for a narrow read |
| arr_rd_stb | output | 1 | One-cycle read start strobe |
| arr_wr_stb | output | 1 | One-cycle write commit strobe |
| arr_wr_addr | output | ADDR_W | Committed write word address |
| arr_wr_data | output | 16 | Committed write data |
| arr_wr_be | output | 2 | Committed byte lanes, bit 1 = upper half |

## Verification
Reads are tried in both widths, with pin 15 at 0 and at 1. This separates a correct half select from a swapped one, and shows whether the unused pins stay released. Writes vary the width, the half-word select bit and the edge that ends the cycle (write enable or chip select). The data changes during the write, so a commit of stale values shows up. Cycles with all three strobes low are run alone and after a write has started, to show that a pending write is dropped. Seeded random sequences of these cycles are mixed with the directed cases.

// File: rtl/dwbp_pkg.sv
package dwbp_pkg;
    localparam int unsigned DQ_W   = 16;
    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_W = DQ_W / LANES;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_CLASH = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic wide;
        logic hi_sel;
    } lane_sel_t;

    function automatic cyc_kind_e classify(input logic cs_n, input logic oe_n, input logic we_n);
        cyc_kind_e k;
        if (cs_n)               k = CYC_IDLE;
        else if (!oe_n && !we_n) k = CYC_CLASH;
        else if (!oe_n)         k = CYC_READ;
        else if (!we_n)         k = CYC_WRITE;
        else                    k = CYC_IDLE;
        return k;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input lane_sel_t s);
        logic [LANES-1:0] m;
        if (s.wide)        m = '1;
        else if (s.hi_sel) m = 2'b10;
        else               m = 2'b01;
        return m;
    endfunction
endpackage

// File: rtl/dwbp_cycle_decode.sv
module dwbp_cycle_decode
    import dwbp_pkg::*;
(
    input  logic      cs_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      wide,
    input  logic      top_pin,
    output cyc_kind_e kind,
    output lane_sel_t sel
);
    always_comb begin
        kind       = classify(cs_n, oe_n, we_n);
        sel.wide   = wide;
        sel.hi_sel = ~wide & top_pin;
    end
endmodule

// File: rtl/dwbp_read_lanes.sv
module dwbp_read_lanes
    import dwbp_pkg::*;
(
    input  cyc_kind_e         kind,
    input  lane_sel_t         sel,
    input  logic [DQ_W-1:0]   word,
    output logic [DQ_W-1:0]   pin_out,
    output logic [DQ_W-1:0]   pin_oe
);
    logic reading;
    assign reading = (kind == CYC_READ);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_on;
        if (g == 0) begin : g_low
            assign lane_on = reading;
            assign pin_out[LANE_W-1:0] = sel.hi_sel ? word[DQ_W-1:LANE_W] : word[LANE_W-1:0];
        end else begin : g_upper
            assign lane_on = reading & sel.wide;
            assign pin_out[g*LANE_W +: LANE_W] = sel.wide ? word[g*LANE_W +: LANE_W] : '0;
        end
        assign pin_oe[g*LANE_W +: LANE_W] = {LANE_W{lane_on}};
    end
endmodule

// File: rtl/dwbp_strobe_gen.sv
module dwbp_strobe_gen
    import dwbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_e         kind,
    input  lane_sel_t         sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   pin_in,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic [LANES-1:0]  wr_be
);
    logic rd_seen_q;
    logic wr_open_q;
    logic [DQ_W-1:0] data_in;

    always_comb begin
        if (sel.wide) data_in = pin_in;
        else          data_in = {LANES{pin_in[LANE_W-1:0]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seen_q <= 1'b0;
            rd_stb    <= 1'b0;
            wr_open_q <= 1'b0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_be     <= '0;
        end else begin
            rd_seen_q <= (kind == CYC_READ);
            rd_stb    <= (kind == CYC_READ) && !rd_seen_q;
            wr_stb    <= wr_open_q && (kind != CYC_WRITE) && (kind != CYC_CLASH);
            if (kind == CYC_WRITE) begin
                wr_open_q <= 1'b1;
                wr_addr   <= addr;
                wr_data   <= data_in;
                wr_be     <= lane_mask(sel);
            end else begin
                wr_open_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_width_bus_port.sv
module dual_width_bus_port
    import dwbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       dq_i,
    output logic [15:0]       dq_o,
    output logic [15:0]       dq_oe,
    input  logic [15:0]       arr_rd_word,
    output logic [ADDR_W-1:0] arr_rd_addr,
    output logic              arr_rd_hi,
    output logic              arr_rd_stb,
    output logic              arr_wr_stb,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [15:0]       arr_wr_data,
    output logic [1:0]        arr_wr_be
);
    cyc_kind_e kind;
    lane_sel_t sel;

    dwbp_cycle_decode u_decode (
        .cs_n    (bus_cs_n),
        .oe_n    (bus_oe_n),
        .we_n    (bus_we_n),
        .wide    (bus_wide),
        .top_pin (dq_i[DQ_W-1]),
        .kind    (kind),
        .sel     (sel)
    );

    dwbp_read_lanes u_read (
        .kind    (kind),
        .sel     (sel),
        .word    (arr_rd_word),
        .pin_out (dq_o),
        .pin_oe  (dq_oe)
    );

    dwbp_strobe_gen #(.ADDR_W(ADDR_W)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .sel     (sel),
        .addr    (bus_addr),
        .pin_in  (dq_i),
        .rd_stb  (arr_rd_stb),
        .wr_stb  (arr_wr_stb),
        .wr_addr (arr_wr_addr),
        .wr_data (arr_wr_data),
        .wr_be   (arr_wr_be)
    );

    assign arr_rd_addr = bus_addr;
    assign arr_rd_hi   = sel.hi_sel;
endmodule

// File: rtl/dwbp_checker.sv
module dwbp_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_cs_n,
    input logic        bus_oe_n,
    input logic        bus_we_n,
    input logic        bus_wide,
    input logic [15:0] dq_oe,
    input logic        arr_rd_stb,
    input logic        arr_wr_stb,
    input logic [1:0]  arr_wr_be
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!arr_wr_stb && !arr_rd_stb)); // R1
    AST_WORD_ALL_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (bus_wide && !bus_cs_n && !bus_oe_n && bus_we_n) |-> (dq_oe == 16'hFFFF)); // R2
    AST_NARROW_UPPER_FLOAT: assert property (@(posedge clk) disable iff (rst)
        !bus_wide |-> (dq_oe[15:8] == 8'h00)); // R3
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (bus_cs_n || bus_oe_n) |-> (dq_oe == 16'h0000)); // R4
    AST_RD_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        arr_rd_stb |=> !arr_rd_stb); // R5
    AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        arr_wr_stb |=> !arr_wr_stb); // R6
    AST_WR_LANES_VALID: assert property (@(posedge clk) disable iff (rst)
        arr_wr_stb |-> ($countones(arr_wr_be) >= 1)); // R8
    AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !bus_oe_n && !bus_we_n) |=> (!arr_wr_stb && !arr_rd_stb)); // R9
endmodule

bind dual_width_bus_port dwbp_checker u_dwbp_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_cs_n   (bus_cs_n),
    .bus_oe_n   (bus_oe_n),
    .bus_we_n   (bus_we_n),
    .bus_wide   (bus_wide),
    .dq_oe      (dq_oe),
    .arr_rd_stb (arr_rd_stb),
    .arr_wr_stb (arr_wr_stb),
    .arr_wr_be  (arr_wr_be)
);

// File: tb/dual_width_bus_port_tb_top.sv
module dual_width_bus_port_tb_top;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_i = '0, arr_word = '0;
    logic [15:0]   dq_o, dq_oe, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          rd_hi, rd_stb, wr_stb;
    logic [1:0]    wr_be;

    int total = 0;
    int bad   = 0;

    dual_width_bus_port #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_wide(wide), .bus_addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .arr_rd_word(arr_word), .arr_rd_addr(rd_addr), .arr_rd_hi(rd_hi),
        .arr_rd_stb(rd_stb), .arr_wr_stb(wr_stb), .arr_wr_addr(wr_addr),
        .arr_wr_data(wr_data), .arr_wr_be(wr_be)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_oe(input bit w);
        return w ? 16'hFFFF : 16'h00FF;
    endfunction

    function automatic logic [15:0] exp_dq(input bit w, input bit hi, input logic [15:0] word);
        if (w) return word;
        return {8'h00, hi ? word[15:8] : word[7:0]};
    endfunction

    function automatic logic [15:0] exp_wdata(input bit w, input logic [15:0] d);
        return w ? d : {d[7:0], d[7:0]};
    endfunction

    function automatic logic [1:0] exp_be(input bit w, input logic [15:0] d);
        if (w) return 2'b11;
        return d[15] ? 2'b10 : 2'b01;
    endfunction

    task automatic go_idle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic read_cycle(input bit w, input logic [AW-1:0] a, input bit hi, input logic [15:0] word);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; wide = w; addr = a;
        dq_i = {hi, 15'($urandom)}; arr_word = word;
        #1;
        chk(w ? "R2 read oe" : "R3 read oe", dq_oe, exp_oe(w));
        chk(w ? "R2 read data" : "R3 read data", dq_o, exp_dq(w, hi, word));
        @(negedge clk);
        chk("R5 rd_stb start", rd_stb, 1);
        chk("R5 rd_addr", rd_addr, a);
        chk("R5 rd_hi", rd_hi, w ? 1'b0 : hi);
        @(negedge clk);
        chk("R5 rd_stb single", rd_stb, 0);
        if ($urandom_range(0, 1) == 0) cs_n = 1'b1; else oe_n = 1'b1;
        #1;
        chk("R4 float after read", dq_oe, 0);
        go_idle();
    endtask

    task automatic write_cycle(input bit w, input logic [AW-1:0] a, input logic [15:0] d,
                               input bit end_by_cs, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; wide = w;
            if (i == len - 1) begin addr = a; dq_i = d; end
            else begin addr = AW'($urandom); dq_i = 16'($urandom); end
            #1;
            chk("R4 no drive in write", dq_oe, 0);
            chk("R6 no early strobe", wr_stb, 0);
        end
        @(negedge clk);
        if (end_by_cs) cs_n = 1'b1; else we_n = 1'b1;
        dq_i = 16'($urandom); addr = AW'($urandom);
        @(negedge clk);
        chk("R6 wr_stb", wr_stb, 1);
        chk("R6 wr_addr", wr_addr, a);
        chk(w ? "R7 wr_data" : "R8 wr_data", wr_data, exp_wdata(w, d));
        chk(w ? "R7 wr_be" : "R8 wr_be", wr_be, exp_be(w, d));
        go_idle();
        @(negedge clk);
        chk("R6 single strobe", wr_stb, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        chk("R1 rd_stb in reset", rd_stb, 0);
        chk("R1 wr_stb in reset", wr_stb, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wr_be after reset", wr_be, 0);
        chk("R1 wr_data after reset", wr_data, 0);
        chk("R1 wr_stb after reset", wr_stb, 0);
        chk("R4 idle float", dq_oe, 0);

        // directed reads
        read_cycle(1'b1, 20'h12345, 1'b1, 16'hBEEF);
        read_cycle(1'b0, 20'h00ABC, 1'b0, 16'hA55A);
        read_cycle(1'b0, 20'h00ABD, 1'b1, 16'hA55A);

        // R3 upper pins stay released in narrow mode while idle and in writes
        @(negedge clk); wide = 1'b0; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
        chk("R3 upper released", dq_oe[15:8], 0);
        go_idle();

        // R4 chip select high with output enable low
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; wide = 1'b1; #1;
        chk("R4 cs high float", dq_oe, 0);
        @(negedge clk);
        chk("R4 cs high no rd_stb", rd_stb, 0);
        go_idle();

        // directed writes
        write_cycle(1'b1, 20'h0F0F0, 16'hC3A5, 1'b0, 2);
        write_cycle(1'b0, 20'h00111, 16'h005A, 1'b1, 3);
        write_cycle(1'b0, 20'h00222, 16'h80E7, 1'b0, 1);

        // R9 clash alone
        @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; #1;
        chk("R9 clash float", dq_oe, 0);
        @(negedge clk);
        chk("R9 clash no rd_stb", rd_stb, 0);
        chk("R9 clash no wr_stb", wr_stb, 0);
        go_idle();

        // R9 write running into a clash is dropped
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; dq_i = 16'h1234;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        chk("R9 dropped write a", wr_stb, 0);
        go_idle();
        @(negedge clk);
        chk("R9 dropped write b", wr_stb, 0);
        @(negedge clk);
        chk("R9 dropped write c", wr_stb, 0);

        // random mix
        for (int n = 0; n < 60; n++) begin
            bit w;
            w = 1'($urandom);
            if ($urandom_range(0, 1) == 0)
                read_cycle(w, AW'($urandom), 1'($urandom), 16'($urandom));
            else
                write_cycle(w, AW'($urandom), 16'($urandom), 1'($urandom), int'($urandom_range(1, 3)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule